// File: doc/BRIEF.md
# Interleaved Prefetch Burst Serializer

This block turns single read commands into four-word bursts on a narrow output. Each accepted command carries one address that is sent at once to four parallel storage banks. Every bank returns one 36-bit word for that address: 32 payload bits plus 4 check bits. The 144-bit group that results is parked in one half of a two-entry ping-pong buffer. A serializer then emits the group one word per clock cycle, starting with bank 0.

The second buffer entry allows a following command to be fetched in the background while the current burst is still leaving. When that group is ready in time, its first word follows the previous burst's last word in the next cycle, so the output streams without idle beats. The banks are plain synchronous arrays with a fixed two-cycle read. Each bank is filled through a simple write port. Check-bit generation and double-rate I/O are handled elsewhere.

Top module: `ibs_burst_serializer`

## Requirements
- R1: After reset, `dvalid` and `dlast` are 0, `dout` is all zeros and `cmd_ready` is 1.
- R2: A cycle with `wr_en` high stores `wr_data` into bank `wr_bank` at row `wr_addr`. A later burst for that row returns the stored word at the position of that bank.
- R3: A command is taken on a rising edge where `cmd_valid` and `cmd_ready` are both 1. `cmd_ready` is 0 exactly when two taken commands have not yet shown their last beat.
- R4: When the output is idle, the first beat of a burst appears on `dout` with `dvalid` = 1 in the third cycle after the edge that took the command.
- R5: The four beats of a burst carry, in this order, the words of bank 0, 1, 2 and 3 at the command's address.
- R6: A burst is four consecutive cycles with `dvalid` = 1. `dlast` is 1 on the fourth beat only.
- R7: When a command is taken no later than one cycle after the previous one, its first beat follows the previous burst's fourth beat in the very next cycle.
- R8: When no further group is ready, `dvalid` drops after the fourth beat and `dout` keeps the last word sent.
- R9: `cmd_valid` asserted while `cmd_ready` is 0 starts no burst. The number of bursts equals the number of taken commands.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| cmd_valid | input | 1 | A read command is offered |
| cmd_ready | output | 1 | A free buffer slot exists, so the command is taken |
| cmd_addr | input | 8 | Row read in all four banks |
| wr_en | input | 1 | Write one word into a bank |
| wr_bank | input | 2 | Bank chosen by the write |
| wr_addr | input | 8 | Row chosen by the write |
| wr_data | input | 36 | Word to store (32 payload bits, 4 check bits) |
| dout | output | 36 | Serialized output word |
| dvalid | output | 1 | `dout` carries a beat of a burst |
| dlast | output | 1 | Current beat is the fourth of its burst |

## Verification
A table of addresses is replayed with three spacings: long idle gaps between commands, which isolate the three-cycle start latency; commands in consecutive cycles, which fill both buffer halves and must give gapless back-to-back bursts; and runs of four or more commands, where the third has to wait on `cmd_ready`, which separates a correct slot release from a premature or late one. Addresses at both ends of the row range, and rows whose bank words differ in every field, show any swap of beat order or bank. Directed cases rewrite one bank word and read it back, offer a command while the buffer is full, and check that the output holds after a burst.

// File: rtl/ibs_pkg.sv
`timescale 1ns/1ps
package ibs_pkg;
   // serializer activity
   typedef enum logic {
      SER_IDLE = 1'b0,
      SER_SEND = 1'b1
   } ser_state_e;

   // number of group buffers (ping-pong)
   localparam int unsigned IBS_NUM_BUFS = 2;
endpackage

// File: rtl/ibs_bank.sv
`timescale 1ns/1ps
module ibs_bank #(
   parameter int unsigned WORD_W       = 36,
   parameter int unsigned ADDR_W       = 8,
   parameter bit          SPLIT_HALVES = 1'b1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [WORD_W-1:0] wr_data,
   input  logic              rd_en,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [WORD_W-1:0] rd_data,
   output logic              rd_valid
);
   localparam int unsigned DEPTH = 1 << ADDR_W;

   if (SPLIT_HALVES && (WORD_W % 2 != 0)) begin : g_chk_half
      $error("ibs_bank: WORD_W must be even when SPLIT_HALVES is set");
   end

   logic [ADDR_W-1:0] addr_q;
   logic              en_q;
   logic [WORD_W-1:0] arr_word;

   // stage one: row capture
   always_ff @(posedge clk) begin
      if (rst) begin
         addr_q <= '0;
         en_q   <= 1'b0;
      end else begin
         en_q <= rd_en;
         if (rd_en) addr_q <= rd_addr;
      end
   end

   // storage array, as one word or as two half-word arrays
   if (SPLIT_HALVES) begin : g_split
      localparam int unsigned HW = WORD_W / 2;
      logic [HW-1:0]        lo_mem [DEPTH];
      logic [WORD_W-HW-1:0] hi_mem [DEPTH];
      always_ff @(posedge clk) begin
         if (wr_en) begin
            lo_mem[wr_addr] <= wr_data[HW-1:0];
            hi_mem[wr_addr] <= wr_data[WORD_W-1:HW];
         end
      end
      assign arr_word = {hi_mem[addr_q], lo_mem[addr_q]};
   end else begin : g_whole
      logic [WORD_W-1:0] mem [DEPTH];
      always_ff @(posedge clk) begin
         if (wr_en) mem[wr_addr] <= wr_data;
      end
      assign arr_word = mem[addr_q];
   end

   // stage two: data register
   always_ff @(posedge clk) begin
      if (rst) begin
         rd_data  <= '0;
         rd_valid <= 1'b0;
      end else begin
         rd_valid <= en_q;
         if (en_q) rd_data <= arr_word;
      end
   end
endmodule

// File: rtl/ibs_pingpong.sv
`timescale 1ns/1ps
module ibs_pingpong
   import ibs_pkg::*;
#(
   parameter int unsigned GROUP_W = 144
) (
   input  logic                                 clk,
   input  logic                                 rst,
   input  logic                                 fill_en,
   input  logic [GROUP_W-1:0]                   fill_data,
   input  logic                                 rel_en,
   input  logic                                 rel_idx,
   output logic [IBS_NUM_BUFS-1:0]              full_q,
   output logic [IBS_NUM_BUFS-1:0][GROUP_W-1:0] grp_q
);
   logic wp_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         wp_q <= 1'b0;
      end else if (fill_en) begin
         wp_q <= ~wp_q;
      end
   end

   for (genvar i = 0; i < IBS_NUM_BUFS; i++) begin : g_buf
      always_ff @(posedge clk) begin
         if (rst) begin
            full_q[i] <= 1'b0;
         end else if (fill_en && (wp_q == 1'(i))) begin
            full_q[i] <= 1'b1;
         end else if (rel_en && (rel_idx == 1'(i))) begin
            full_q[i] <= 1'b0;
         end
      end

      always_ff @(posedge clk) begin
         if (fill_en && (wp_q == 1'(i))) grp_q[i] <= fill_data;
      end
   end
endmodule

// File: rtl/ibs_serializer.sv
`timescale 1ns/1ps
module ibs_serializer
   import ibs_pkg::*;
#(
   parameter int unsigned NUM_BANKS = 4,
   parameter int unsigned WORD_W    = 36
) (
   input  logic                                           clk,
   input  logic                                           rst,
   input  logic [IBS_NUM_BUFS-1:0]                        full,
   input  logic [IBS_NUM_BUFS-1:0][NUM_BANKS*WORD_W-1:0]  grp,
   output logic                                           rel_en,
   output logic                                           rel_idx,
   output logic [WORD_W-1:0]                              dout,
   output logic                                           dvalid,
   output logic                                           dlast
);
   localparam int unsigned GROUP_W = NUM_BANKS * WORD_W;
   localparam int unsigned BEAT_W  = $clog2(NUM_BANKS);
   localparam logic [BEAT_W-1:0] LAST_BEAT = BEAT_W'(NUM_BANKS - 1);

   ser_state_e        state_q;
   logic [BEAT_W-1:0] beat_q;
   logic              rp_q;

   logic              nxt_idx;
   logic              done;
   logic              start;
   logic [BEAT_W-1:0] beat_inc;
   logic [GROUP_W-1:0] src_grp;
   logic [BEAT_W-1:0] src_beat;
   logic [WORD_W-1:0] src_word;

   always_comb begin
      nxt_idx  = (state_q == SER_SEND) ? ~rp_q : rp_q;
      done     = (state_q == SER_SEND) && (beat_q == LAST_BEAT);
      start    = ((state_q == SER_IDLE) || done) && full[nxt_idx];
      beat_inc = beat_q + 1'b1;
      src_grp  = start ? grp[nxt_idx] : grp[rp_q];
      src_beat = start ? '0 : beat_inc;
      src_word = src_grp[int'(src_beat)*WORD_W +: WORD_W];
   end

   assign rel_en  = done;
   assign rel_idx = rp_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         state_q <= SER_IDLE;
         beat_q  <= '0;
         rp_q    <= 1'b0;
         dout    <= '0;
         dvalid  <= 1'b0;
         dlast   <= 1'b0;
      end else if (start) begin
         state_q <= SER_SEND;
         rp_q    <= nxt_idx;
         beat_q  <= '0;
         dout    <= src_word;
         dvalid  <= 1'b1;
         dlast   <= 1'b0;
      end else if ((state_q == SER_SEND) && !done) begin
         beat_q  <= beat_inc;
         dout    <= src_word;
         dvalid  <= 1'b1;
         dlast   <= (beat_inc == LAST_BEAT);
      end else begin
         if (done) begin
            state_q <= SER_IDLE;
            rp_q    <= ~rp_q;
         end
         dvalid <= 1'b0;
         dlast  <= 1'b0;
      end
   end
endmodule

// File: rtl/ibs_burst_serializer.sv
`timescale 1ns/1ps
module ibs_burst_serializer
   import ibs_pkg::*;
#(
   parameter int unsigned NUM_BANKS    = 4,
   parameter int unsigned WORD_W       = 36,
   parameter int unsigned ADDR_W       = 8,
   parameter bit          SPLIT_HALVES = 1'b1
) (
   input  logic                         clk,
   input  logic                         rst,
   input  logic                         cmd_valid,
   output logic                         cmd_ready,
   input  logic [ADDR_W-1:0]            cmd_addr,
   input  logic                         wr_en,
   input  logic [$clog2(NUM_BANKS)-1:0] wr_bank,
   input  logic [ADDR_W-1:0]            wr_addr,
   input  logic [WORD_W-1:0]            wr_data,
   output logic [WORD_W-1:0]            dout,
   output logic                         dvalid,
   output logic                         dlast
);
   localparam int unsigned GROUP_W = NUM_BANKS * WORD_W;
   localparam int unsigned SEL_W   = $clog2(NUM_BANKS);
   localparam int unsigned SLOT_W  = $clog2(IBS_NUM_BUFS + 1);

   if ((NUM_BANKS < 2) || ((NUM_BANKS & (NUM_BANKS - 1)) != 0)) begin : g_chk_banks
      $error("ibs_burst_serializer: NUM_BANKS must be a power of two, at least 2");
   end
   if (WORD_W < 2) begin : g_chk_word
      $error("ibs_burst_serializer: WORD_W too small");
   end

   logic                                  accept;
   logic [SLOT_W-1:0]                     slots_q;
   logic [NUM_BANKS-1:0]                  bank_vld;
   logic [GROUP_W-1:0]                    group_w;
   logic                                  rel_en;
   logic                                  rel_idx;
   logic [IBS_NUM_BUFS-1:0]               full_q;
   logic [IBS_NUM_BUFS-1:0][GROUP_W-1:0]  grp_q;

   // slot accounting: a slot is held from acceptance until its burst ends
   assign cmd_ready = (slots_q < SLOT_W'(IBS_NUM_BUFS));
   assign accept    = cmd_valid && cmd_ready;

   always_ff @(posedge clk) begin
      if (rst) begin
         slots_q <= '0;
      end else begin
         case ({accept, rel_en})
            2'b10:   slots_q <= slots_q + 1'b1;
            2'b01:   slots_q <= slots_q - 1'b1;
            default: slots_q <= slots_q;
         endcase
      end
   end

   // interleaved banks, all fired by one command
   for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
      ibs_bank #(
         .WORD_W       (WORD_W),
         .ADDR_W       (ADDR_W),
         .SPLIT_HALVES (SPLIT_HALVES)
      ) u_bank (
         .clk      (clk),
         .rst      (rst),
         .wr_en    (wr_en && (wr_bank == SEL_W'(b))),
         .wr_addr  (wr_addr),
         .wr_data  (wr_data),
         .rd_en    (accept),
         .rd_addr  (cmd_addr),
         .rd_data  (group_w[b*WORD_W +: WORD_W]),
         .rd_valid (bank_vld[b])
      );
   end

   ibs_pingpong #(
      .GROUP_W (GROUP_W)
   ) u_pingpong (
      .clk       (clk),
      .rst       (rst),
      .fill_en   (&bank_vld),
      .fill_data (group_w),
      .rel_en    (rel_en),
      .rel_idx   (rel_idx),
      .full_q    (full_q),
      .grp_q     (grp_q)
   );

   ibs_serializer #(
      .NUM_BANKS (NUM_BANKS),
      .WORD_W    (WORD_W)
   ) u_ser (
      .clk     (clk),
      .rst     (rst),
      .full    (full_q),
      .grp     (grp_q),
      .rel_en  (rel_en),
      .rel_idx (rel_idx),
      .dout    (dout),
      .dvalid  (dvalid),
      .dlast   (dlast)
   );
endmodule

// File: rtl/ibs_checker.sv
`timescale 1ns/1ps
module ibs_checker #(
   parameter int unsigned WORD_W = 36
) (
   input logic              clk,
   input logic              rst,
   input logic              cmd_valid,
   input logic              cmd_ready,
   input logic [WORD_W-1:0] dout,
   input logic              dvalid,
   input logic              dlast
);
   logic       took;
   logic [2:0] open_cnt;

   assign took = cmd_valid && cmd_ready;

   // independent count of commands whose burst has not ended
   always_ff @(posedge clk) begin
      if (rst) begin
         open_cnt <= '0;
      end else begin
         open_cnt <= open_cnt + 3'(took) - 3'(dvalid && dlast);
      end
   end

   assert_ready_slots_R3: assert property (@(posedge clk) disable iff (rst)
      cmd_ready == (open_cnt < 3'd2))
      else $error("cmd_ready disagrees with outstanding count");

   assert_first_beat_R4: assert property (@(posedge clk) disable iff (rst)
      $rose(dvalid) |-> $past(took, 4))
      else $error("burst started without a command three cycles before");

   assert_last_in_burst_R6: assert property (@(posedge clk) disable iff (rst)
      dlast |-> dvalid)
      else $error("dlast outside a burst");

   assert_no_bubble_R6: assert property (@(posedge clk) disable iff (rst)
      (dvalid && !dlast) |=> dvalid)
      else $error("gap inside a burst");

   assert_hold_idle_R8: assert property (@(posedge clk) disable iff (rst)
      !dvalid |-> $stable(dout))
      else $error("dout moved while idle");
endmodule

bind ibs_burst_serializer ibs_checker #(
   .WORD_W (WORD_W)
) chk_i (
   .clk       (clk),
   .rst       (rst),
   .cmd_valid (cmd_valid),
   .cmd_ready (cmd_ready),
   .dout      (dout),
   .dvalid    (dvalid),
   .dlast     (dlast)
);

// File: tb/ibs_burst_serializer_tb_top.sv
`timescale 1ns/1ps
module ibs_burst_serializer_tb_top;
   localparam int unsigned NB = 4;
   localparam int unsigned W  = 36;
   localparam int unsigned AW = 8;
   localparam int unsigned NV = 12;

   // each entry: {idle spacing code [9:8], address [7:0]}; spacing code 0 = next cycle
   localparam logic [9:0] VECS [NV] = '{
      {2'd3, 8'h00}, {2'd0, 8'h01}, {2'd0, 8'h02}, {2'd2, 8'h7F},
      {2'd0, 8'hFF}, {2'd1, 8'h80}, {2'd3, 8'h33}, {2'd0, 8'h34},
      {2'd0, 8'h35}, {2'd0, 8'h36}, {2'd1, 8'hAA}, {2'd3, 8'h55}
   };

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic          cmd_valid = 1'b0;
   logic          cmd_ready;
   logic [AW-1:0] cmd_addr = '0;
   logic          wr_en = 1'b0;
   logic [1:0]    wr_bank = '0;
   logic [AW-1:0] wr_addr = '0;
   logic [W-1:0]  wr_data = '0;
   logic [W-1:0]  dout;
   logic          dvalid;
   logic          dlast;

   ibs_burst_serializer #(
      .NUM_BANKS (NB), .WORD_W (W), .ADDR_W (AW)
   ) dut_i (
      .clk (clk), .rst (rst), .cmd_valid (cmd_valid), .cmd_ready (cmd_ready),
      .cmd_addr (cmd_addr), .wr_en (wr_en), .wr_bank (wr_bank),
      .wr_addr (wr_addr), .wr_data (wr_data), .dout (dout),
      .dvalid (dvalid), .dlast (dlast)
   );

   always #4 clk = ~clk;

   int n_chk = 0;
   int n_bad = 0;
   int cyc = 0;
   always @(posedge clk) cyc <= cyc + 1;

   logic [W-1:0] mdl [NB][1<<AW];
   int q_addr [64];
   int q_start [64];
   int head = 0;
   int tail = 0;
   int model_end = -10;
   int bursts = 0;
   bit mon_on = 1'b0;

   function automatic logic [W-1:0] pat(input int b, input int a);
      return {4'(b * 3 + a), 8'(a), 8'(~a), 4'(b), 12'(a * 7 + b * 301)};
   endfunction

   task automatic check(input bit ok, input string req, input logic [63:0] act,
                        input logic [63:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", req, act, exp, cyc);
      end
   endtask

   task automatic summary();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
   endtask

   task automatic send(input logic [AW-1:0] a);
      int acc;
      int st;
      @(negedge clk);
      cmd_valid = 1'b1;
      cmd_addr  = a;
      while (!cmd_ready) @(negedge clk);
      acc = cyc + 1;
      st  = (acc + 3 > model_end + 1) ? acc + 3 : model_end + 1;
      model_end = st + 3;
      q_addr[tail % 64]  = int'(a);
      q_start[tail % 64] = st;
      tail++;
      @(posedge clk);
      #1 cmd_valid = 1'b0;
   endtask

   task automatic write_word(input int b, input int a, input logic [W-1:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_bank = 2'(b); wr_addr = AW'(a); wr_data = d;
      mdl[b][a] = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   // output monitor: data (R5), end flag (R6), start cycle (R4, R7), hold (R8), extra bursts (R9)
   int mbeat = 0;
   logic prev_v = 1'b0;
   logic [W-1:0] prev_d = '0;
   always @(negedge clk) begin
      if (mon_on) begin
         if (dvalid) begin
            if (head == tail) begin
               check(1'b0, "R9 unexpected beat", 64'(dout), 64'(0));
            end else begin
               check(dout == mdl[mbeat][q_addr[head % 64]], "R5 beat data",
                     64'(dout), 64'(mdl[mbeat][q_addr[head % 64]]));
               check(dlast == (mbeat == 3), "R6 last flag", 64'(dlast), 64'(mbeat == 3));
               if (mbeat == 0)
                  check(cyc == q_start[head % 64], "R4 R7 first beat cycle",
                        64'(cyc), 64'(q_start[head % 64]));
               mbeat++;
               if (mbeat == NB) begin
                  mbeat = 0;
                  head++;
                  bursts++;
               end
            end
         end else if (prev_v) begin
            check(dout == prev_d, "R8 hold after burst", 64'(dout), 64'(prev_d));
            check(mbeat == 0, "R6 burst cut short", 64'(mbeat), 64'(0));
         end
      end
      prev_v = dvalid;
      prev_d = dout;
   end

   initial begin
      repeat (150000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog R6 run hung actual=%0d expected<%0d", cyc, 150000);
      summary();
      $finish;
   end

   initial begin
      int run;
      int b0;
      repeat (5) @(posedge clk);
      @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
      // R1: reset state
      check(dvalid == 1'b0, "R1 dvalid", 64'(dvalid), 64'(0));
      check(dlast == 1'b0, "R1 dlast", 64'(dlast), 64'(0));
      check(cmd_ready == 1'b1, "R1 cmd_ready", 64'(cmd_ready), 64'(1));
      check(dout == '0, "R1 dout", 64'(dout), 64'(0));

      // fill all banks (R2 write path)
      for (int b = 0; b < NB; b++)
         for (int a = 0; a < (1 << AW); a++) begin
            @(negedge clk);
            wr_en = 1'b1; wr_bank = 2'(b); wr_addr = AW'(a); wr_data = pat(b, a);
            mdl[b][a] = pat(b, a);
         end
      @(negedge clk);
      wr_en = 1'b0;
      mon_on = 1'b1;

      // table walk: spacings give isolated, back-to-back and stalled commands
      for (int v = 0; v < NV; v++) begin
         repeat (int'(VECS[v][9:8]) * 5) @(negedge clk);
         send(VECS[v][7:0]);
      end
      repeat (30) @(negedge clk);
      check(head == tail, "R9 all bursts delivered", 64'(head), 64'(tail));

      // R2: rewrite one bank word and read it back at bank 2 position
      write_word(2, 5, 36'h9_DEAD_BEEF);
      send(8'h05);
      repeat (12) @(negedge clk);
      check(head == tail, "R2 rewritten row read", 64'(head), 64'(tail));
      // R8: dout keeps last beat (bank 3 of row 5)
      check(dout == mdl[3][5], "R8 dout held", 64'(dout), 64'(mdl[3][5]));

      // R3, R7, R9: fill both slots, offer a command while full
      b0 = bursts;
      send(8'h10);
      send(8'h11);
      @(negedge clk);
      check(cmd_ready == 1'b0, "R3 ready low with two open", 64'(cmd_ready), 64'(0));
      cmd_valid = 1'b1;
      cmd_addr  = 8'hC3;
      @(negedge clk);
      cmd_valid = 1'b0;
      run = 0;
      while (!dvalid) @(negedge clk);
      while (dvalid) begin
         run++;
         @(negedge clk);
      end
      // R7: two bursts joined without a bubble
      check(run == 2 * NB, "R7 gapless run length", 64'(run), 64'(2 * NB));
      repeat (12) @(negedge clk);
      check(bursts - b0 == 2, "R9 refused command ignored", 64'(bursts - b0), 64'(2));
      check(cmd_ready == 1'b1, "R3 ready back after drain", 64'(cmd_ready), 64'(1));

      summary();
      $finish;
   end
endmodule